// File: doc/BRIEF.md
# Byte Insert Under Mask

This unit merges bytes from memory into a 32-bit register value. A 4-bit mask picks which byte lanes of the register receive new data. Bytes are read one at a time from consecutive addresses starting at a base address. They are placed into the selected lanes starting at the most significant selected lane. Lanes that are not selected keep their old contents.

Along with the merged value, the unit produces a 2-bit condition code. The code is computed from the inserted bytes alone. When the mask is zero, the unit still issues a single read at the base address, so that the memory system can check access rights for one byte. In that case the register value is returned unchanged.

An operation begins with a one-cycle `start` while the unit is idle. A read request stays raised until memory answers with `rd_valid`. `done` pulses for one cycle once the operation has finished.

Top module: `byte_insert_mask`

## Requirements
- R1: Mask bit 3 selects register bits 31:24, bit 2 selects 23:16, bit 1 selects 15:8 and bit 0 selects 7:0.
- R2: Selected lanes are filled from the most significant lane downward. The first lane takes the byte at the base address, and each following lane takes the byte at the next higher address. `rd_addr` holds steady while a request waits, and it advances by one after each accepted byte.
- R3: With a nonzero mask, the number of reads equals the number of ones in the mask.
- R4: Lanes whose mask bit is 0 carry the old register value in `reg_out`.
- R5: `cc` is 0 when the mask is zero or when every inserted bit is zero.
- R6: `cc` is 1 when the inserted bits are not all zero and the most significant bit of the first inserted byte is 1.
- R7: `cc` is 2 when the inserted bits are not all zero and the most significant bit of the first inserted byte is 0.
- R8: With a zero mask, exactly one read is made, at the base address, and `reg_out` equals the old register value.
- R9: `done` is high for exactly one cycle, in the cycle after the last byte is accepted. `reg_out` and `cc` change only when `done` is high, and they hold their values until the next operation completes.
- R10: A `start` raised while an operation is in progress is ignored.
- R11: After reset, `rd_req` and `done` are 0, `reg_out` is 0 and `cc` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (sampled only while idle) |
| mask | input | 4 | Lane select mask |
| base_addr | input | AW | Address of the first byte |
| reg_in | input | 32 | Old register value |
| rd_req | output | 1 | Byte read request |
| rd_addr | output | AW | Byte read address |
| rd_valid | input | 1 | Read data valid; the request is accepted in this cycle |
| rd_data | input | 8 | Read data |
| reg_out | output | 32 | Merged register value |
| cc | output | 2 | Condition code |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that memory raises `rd_valid` only while `rd_req` is high. One of them checks this assumption directly. The assertions also assume that `start` is a single-cycle pulse.

The bench memory model answers only a pending request, after a programmable wait, and drops `rd_valid` in the following cycle. This keeps the stimulus within those assumptions even at zero wait. A `start` pulse during a busy operation is sent on purpose, to exercise the ignore rule.

// File: rtl/byte_insert_mask.sv
module byte_insert_mask #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mask,
  input  logic [AW-1:0] base_addr,
  input  logic [31:0]   reg_in,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_valid,
  input  logic [7:0]    rd_data,
  output logic [31:0]   reg_out,
  output logic [1:0]    cc,
  output logic          done
);
  typedef enum logic [1:0] {S_IDLE, S_PROBE, S_FETCH} st_t;
  st_t st;

  logic [3:0]  pend, mask_q;
  logic [31:0] acc, old_q, acc_n;
  logic        nz, first_bit, seen;
  logic [1:0]  lane;
  logic [3:0]  pend_n;
  logic        nz_n, fb_n;
  logic [1:0]  cc_n;

  assign rd_req = (st != S_IDLE);

  always_comb begin
    if (pend[3])      lane = 2'd3;
    else if (pend[2]) lane = 2'd2;
    else if (pend[1]) lane = 2'd1;
    else              lane = 2'd0;
    acc_n = acc;
    acc_n[{lane, 3'b000} +: 8] = rd_data;
    pend_n = pend;
    pend_n[lane] = 1'b0;
    nz_n = nz | (|rd_data);
    fb_n = seen ? first_bit : rd_data[7];
    cc_n = nz_n ? (fb_n ? 2'd1 : 2'd2) : 2'd0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pend      <= '0;
      mask_q    <= '0;
      acc       <= '0;
      old_q     <= '0;
      nz        <= 1'b0;
      first_bit <= 1'b0;
      seen      <= 1'b0;
      rd_addr   <= '0;
      reg_out   <= '0;
      cc        <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          mask_q  <= mask;
          pend    <= mask;
          rd_addr <= base_addr;
          acc     <= reg_in;
          old_q   <= reg_in;
          nz      <= 1'b0;
          seen    <= 1'b0;
          st      <= (mask == 4'd0) ? S_PROBE : S_FETCH;
        end
        S_PROBE: if (rd_valid) begin
          st      <= S_IDLE;
          done    <= 1'b1;
          reg_out <= acc;
          cc      <= 2'd0;
        end
        S_FETCH: if (rd_valid) begin
          acc       <= acc_n;
          pend      <= pend_n;
          nz        <= nz_n;
          first_bit <= fb_n;
          seen      <= 1'b1;
          rd_addr   <= rd_addr + AW'(1);
          if (pend_n == 4'd0) begin
            st      <= S_IDLE;
            done    <= 1'b1;
            reg_out <= acc_n;
            cc      <= cc_n;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [31:0] keep_lanes;
  assign keep_lanes = {{8{~mask_q[3]}}, {8{~mask_q[2]}}, {8{~mask_q[1]}}, {8{~mask_q[0]}}};

  AST_VALID_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> rd_req); // R2
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr))); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && rd_valid) |=> (done || rd_addr == $past(rd_addr) + AW'(1))); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(reg_out) && $stable(cc))); // R9
  AST_KEEP_LANES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (((reg_out ^ old_q) & keep_lanes) == 32'd0)); // R4
  AST_ZERO_MASK_CC: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mask_q == 4'd0) |-> (cc == 2'd0 && reg_out == old_q)); // R8
  AST_CC_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cc != 2'd3)); // R5
endmodule

// File: tb/byte_insert_mask_tb.sv
`timescale 1ns/1ps
module byte_insert_mask_tb;
  localparam int AW = 16;
  logic clk = 0, rst_n = 0, start = 0, rd_valid = 0;
  logic [3:0] mask = 0;
  logic [AW-1:0] base_addr = 0;
  logic [31:0] reg_in = 0;
  logic [7:0] rd_data = 0;
  logic rd_req, done;
  logic [AW-1:0] rd_addr;
  logic [31:0] reg_out;
  logic [1:0] cc;

  byte_insert_mask #(.AW(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .mask(mask), .base_addr(base_addr),
    .reg_in(reg_in), .rd_req(rd_req), .rd_addr(rd_addr), .rd_valid(rd_valid),
    .rd_data(rd_data), .reg_out(reg_out), .cc(cc), .done(done));

  always #2 clk = ~clk;

  int total = 0, bad = 0, cycles = 0;
  int lat = 0, wait_cnt = 0, nacc = 0;
  logic [7:0] mem [0:255];
  logic [AW-1:0] addr_log [0:7];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'((i * 37 + 11) ^ (i >> 2));
    forever begin
      @(negedge clk);
      if (rd_valid) rd_valid = 0;
      else if (rd_req) begin
        if (wait_cnt >= lat) begin
          rd_valid = 1;
          rd_data = mem[rd_addr[7:0]];
          if (nacc < 8) addr_log[nacc] = rd_addr;
          nacc++;
          wait_cnt = 0;
        end else wait_cnt++;
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  task automatic run_op(string tag, logic [3:0] m, logic [AW-1:0] b, logic [31:0] old, int l, bit poke);
    logic [31:0] exp;
    int n, t;
    logic nzb, fb, first;
    logic [AW-1:0] a;
    logic [31:0] got;
    logic [1:0] gotcc, expcc;
    exp = old; a = b; n = 0; nzb = 0; fb = 0; first = 1;
    for (int ln = 3; ln >= 0; ln--) begin
      if (m[ln]) begin
        exp[ln*8 +: 8] = mem[a[7:0]];
        if (first) fb = mem[a[7:0]][7];
        first = 0;
        if (mem[a[7:0]] != 0) nzb = 1;
        a = a + AW'(1); n++;
      end
    end
    if (m == 0) n = 1;
    expcc = !nzb ? 2'd0 : (fb ? 2'd1 : 2'd2);
    lat = l; nacc = 0; wait_cnt = 0;
    @(negedge clk);
    mask = m; base_addr = b; reg_in = old; start = 1;
    @(negedge clk);
    start = 0;
    if (poke) begin
      @(negedge clk);
      mask = 4'hF; base_addr = 16'h0080; reg_in = 32'hFFFF_FFFF; start = 1;
      @(negedge clk);
      start = 0;
    end
    t = 0;
    while (!done && t < 1000) begin @(negedge clk); t++; end
    chk({tag, " R9 done seen"}, 32'(done), 32'd1);
    got = reg_out; gotcc = cc;
    chk({tag, " R1 R4 reg_out"}, got, exp);
    chk({tag, " R5 R6 R7 cc"}, 32'(gotcc), 32'(expcc));
    chk({tag, " R3 R8 R10 read count"}, 32'(nacc), 32'(n));
    for (int i = 0; i < n && i < 8; i++) chk({tag, " R2 addr"}, 32'(addr_log[i]), 32'(b + AW'(i)));
    @(negedge clk);
    chk({tag, " R9 done one cycle"}, 32'(done), 32'd0);
    repeat (3) @(negedge clk);
    chk({tag, " R9 reg_out hold"}, reg_out, got);
    chk({tag, " R9 cc hold"}, 32'(cc), 32'(gotcc));
  endtask

  task automatic t_reset();
    chk("R11 rd_req", 32'(rd_req), 0);
    chk("R11 done", 32'(done), 0);
    chk("R11 reg_out", reg_out, 0);
    chk("R11 cc", 32'(cc), 0);
  endtask

  task automatic t_full();
    mem[16] = 8'h81; mem[17] = 8'h22; mem[18] = 8'h33; mem[19] = 8'h44;
    run_op("full R6", 4'hF, 16'd16, 32'hDEAD_BEEF, 0, 0);
  endtask

  task automatic t_lanes();
    mem[40] = 8'h5A;
    run_op("lane0 R1", 4'b0001, 16'd40, 32'h1122_3344, 1, 0);
    run_op("lane3 R1", 4'b1000, 16'd40, 32'h1122_3344, 2, 0);
    run_op("lane1 R1", 4'b0010, 16'd40, 32'hA0B0_C0D0, 0, 0);
  endtask

  task automatic t_sparse();
    mem[60] = 8'h00; mem[61] = 8'h7F;
    run_op("sparse R7", 4'b1010, 16'd60, 32'hCAFE_F00D, 1, 0);
    mem[70] = 8'h01; mem[71] = 8'hF0; mem[72] = 8'h00;
    run_op("three R3", 4'b0111, 16'd70, 32'h0000_0000, 3, 0);
  endtask

  task automatic t_zero_data();
    mem[90] = 8'h00; mem[91] = 8'h00;
    run_op("zero data R5", 4'b0110, 16'd90, 32'hFFFF_FFFF, 0, 0);
  endtask

  task automatic t_zero_mask();
    mem[100] = 8'hFF;
    run_op("zero mask R8", 4'b0000, 16'd100, 32'h1357_9BDF, 2, 0);
  endtask

  task automatic t_busy_start();
    mem[120] = 8'h12; mem[121] = 8'h80;
    run_op("busy start R10", 4'b1001, 16'd120, 32'h0F0F_0F0F, 4, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_full();
    t_lanes();
    t_sparse();
    t_zero_data();
    t_zero_mask();
    t_busy_start();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule